// File: doc/BRIEF.md
# Three-Phase Gate Interlock and Short-Circuit Fault Controller

This block sits between the PWM modulator and the gate drivers of a three-phase inverter with a brake chopper. It takes active-low arm commands, one pair per phase plus one for the brake. From them it produces active-high gate enables. No phase may ever have both of its switches on.

If a phase is commanded with both arms on, both switches of that phase are turned off and the phase is locked out. The lock holds until each of the two commands has started a fresh pulse. The phase is released on the start edge of whichever pulse comes second.

Each of the six bridge switches also has a digital overcurrent sense bit. The bit must stay high for a programmable number of clocks before it counts. When it counts, only that switch is shut off, and only for the rest of its current command pulse; the next pulse re-enables it. The brake switch has no sense input and simply follows its command.

An active-low fault output reports any locked phase or any tripped switch. All inputs pass through two-flop synchronizers before any decision is made.

Top module: `gate_interlock_ctrl`

## Requirements
- R1: While `rst` is high, and after it until a command is seen low, every gate enable is 0 and `faultN` is 1.
- R2: Commands are active low. A command driven low reaches its gate enable after exactly two rising clock edges (synchronizer latency), provided the opposite arm of the phase is high.
- R3: `gateUp[p]` and `gateLo[p]` are never both 1 for any phase p.
- R4: When `cmdUpN[p]` and `cmdLoN[p]` are both low, both gate enables of phase p go to 0 and `faultN` goes to 0.
- R5: The phase-p lockout persists after the overlap ends: both gates of phase p stay 0 and `faultN` stays 0 whatever the commands do. The other phases keep following their commands.
- R6: A locked phase is released only by falling edges. Each of its two commands must show a falling edge after the lockout, and release happens on the later of the two, in either order. A single arm restarting its pulse does not release the phase.
- R7: `scSense[i]` trips switch i only after it has been high for `FILT_LEN` consecutive clocks (default 4). A pulse of `FILT_LEN-1` clocks has no effect. Bit i < 3 is the upper switch of phase i; bit 3+i is the lower switch of phase i.
- R8: A trip turns off only gate i and drives `faultN` to 0. Both persist after the sense bit clears and after the command is released. Both end at the next falling edge of that switch's command.
- R9: `gateBrk` is 1 exactly when the synchronized `brkCmdN` is low. No sense input affects it.
- R10: `faultN` is 0 exactly while some phase is locked out or some switch is tripped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdUpN | input | 3 | Upper-arm commands per phase, active low |
| cmdLoN | input | 3 | Lower-arm commands per phase, active low |
| brkCmdN | input | 1 | Brake switch command, active low |
| scSense | input | 6 | Overcurrent sense per bridge switch (bits 0..2 upper, 3..5 lower) |
| gateUp | output | 3 | Upper-arm gate enables, active high |
| gateLo | output | 3 | Lower-arm gate enables, active high |
| gateBrk | output | 1 | Brake gate enable, active high |
| faultN | output | 1 | Fault flag, active low |

## Verification
All 128 combinations of the six arm commands and the brake command are swept from a clean reset. This separates correct single-arm conduction from overlap detection on each phase independently, including several phases overlapping at once.

Directed sequences then probe the lockout. They hold overlap, release one arm, and restart one arm only, which tells a proper two-edge release from a premature one-edge release. The release order is reversed on another phase.

Sense pulses one clock shorter than the filter and exactly as long as the filter tell the delay threshold apart. Trips on upper and lower switches show the shutdown stays local to one switch and lasts until the next pulse begins. A brake command under full overcurrent shows the brake exemption.

// File: rtl/gic_pkg.sv
package gic_pkg;
  localparam int PHASES = 3;
  localparam int SW     = 2 * PHASES;

  // events found by the datapath, consumed by the control
  typedef struct packed {
    logic [SW-1:0]     cmdFall;  // pulse start (high-to-low) per switch
    logic [PHASES-1:0] overlap;  // both arms requested
    logic [SW-1:0]     scHit;    // filtered overcurrent
  } evt_t;

  // strobes from the control back to the datapath
  typedef struct packed {
    logic [PHASES-1:0] ilkHold;  // phase locked out
    logic [SW-1:0]     scHold;   // switch tripped
  } strb_t;
endpackage

// File: rtl/gic_datapath.sv
module gic_datapath
  import gic_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PHASES-1:0] cmdUpN,
  input  logic [PHASES-1:0] cmdLoN,
  input  logic              brkCmdN,
  input  logic [SW-1:0]     scSense,
  input  strb_t             strb,
  output evt_t              evt,
  output logic [PHASES-1:0] gateUp,
  output logic [PHASES-1:0] gateLo,
  output logic              gateBrk,
  output logic              faultN
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(FILT_LEN);
  localparam logic [CW-1:0] HIT_AT  = CW'(FILT_LEN - 1);

  logic [SW-1:0] cmdS1, cmdS2, cmdPrev;
  logic [SW-1:0] senS1, senS2;
  logic          brkS1, brkS2;
  logic [SW-1:0] cmdOn, cmdFall, scHit;
  logic [PHASES-1:0] overlap;

  // two-flop synchronizers plus one stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      cmdS1   <= '1;
      cmdS2   <= '1;
      cmdPrev <= '1;
      brkS1   <= 1'b1;
      brkS2   <= 1'b1;
      senS1   <= '0;
      senS2   <= '0;
    end else begin
      cmdS1   <= {cmdLoN, cmdUpN};
      cmdS2   <= cmdS1;
      cmdPrev <= cmdS2;
      brkS1   <= brkCmdN;
      brkS2   <= brkS1;
      senS1   <= scSense;
      senS2   <= senS1;
    end
  end

  assign cmdOn   = ~cmdS2;
  assign cmdFall = cmdPrev & ~cmdS2;

  // per-switch delay filter: saturating run-length counter
  for (genvar i = 0; i < SW; i++) begin : g_filt
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst || !senS2[i]) cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
    assign scHit[i] = senS2[i] && (cnt >= HIT_AT);
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    assign overlap[p] = cmdOn[p] & cmdOn[p+PHASES];
    assign gateUp[p]  = cmdOn[p] & ~overlap[p] & ~strb.ilkHold[p] & ~strb.scHold[p];
    assign gateLo[p]  = cmdOn[p+PHASES] & ~overlap[p] & ~strb.ilkHold[p]
                        & ~strb.scHold[p+PHASES];
  end

  always_comb begin
    evt.cmdFall = cmdFall;
    evt.overlap = overlap;
    evt.scHit   = scHit;
  end

  assign gateBrk = ~brkS2;
  assign faultN  = ~((|strb.ilkHold) | (|strb.scHold));
endmodule

// File: rtl/gic_control.sv
module gic_control
  import gic_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  evt_t  evt,
  output strb_t strb
);
  logic [PHASES-1:0] ilk;
  logic [SW-1:0]     sc;

  // lockout per phase, released on the later of the two pulse starts
  for (genvar p = 0; p < PHASES; p++) begin : g_ilk
    logic seenUp, seenLo, nextUp, nextLo;
    assign nextUp = seenUp | evt.cmdFall[p];
    assign nextLo = seenLo | evt.cmdFall[p+PHASES];
    always_ff @(posedge clk) begin
      if (rst) begin
        ilk[p] <= 1'b0;
        seenUp <= 1'b0;
        seenLo <= 1'b0;
      end else if (evt.overlap[p]) begin
        ilk[p] <= 1'b1;
        seenUp <= 1'b0;
        seenLo <= 1'b0;
      end else if (ilk[p]) begin
        if (nextUp && nextLo) begin
          ilk[p] <= 1'b0;
          seenUp <= 1'b0;
          seenLo <= 1'b0;
        end else begin
          seenUp <= nextUp;
          seenLo <= nextLo;
        end
      end
    end
  end

  // pulse-by-pulse trip per switch
  for (genvar i = 0; i < SW; i++) begin : g_sc
    always_ff @(posedge clk) begin
      if (rst) sc[i] <= 1'b0;
      else     sc[i] <= evt.scHit[i] | (sc[i] & ~evt.cmdFall[i]);
    end
  end

  always_comb begin
    strb.ilkHold = ilk;
    strb.scHold  = sc;
  end
endmodule

// File: rtl/gate_interlock_ctrl.sv
module gate_interlock_ctrl
  import gic_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PHASES-1:0] cmdUpN,
  input  logic [PHASES-1:0] cmdLoN,
  input  logic              brkCmdN,
  input  logic [SW-1:0]     scSense,
  output logic [PHASES-1:0] gateUp,
  output logic [PHASES-1:0] gateLo,
  output logic              gateBrk,
  output logic              faultN
);
  evt_t  evt;
  strb_t strb;

  gic_datapath #(.FILT_LEN(FILT_LEN)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .cmdUpN  (cmdUpN),
    .cmdLoN  (cmdLoN),
    .brkCmdN (brkCmdN),
    .scSense (scSense),
    .strb    (strb),
    .evt     (evt),
    .gateUp  (gateUp),
    .gateLo  (gateLo),
    .gateBrk (gateBrk),
    .faultN  (faultN)
  );

  gic_control u_ctl (
    .clk  (clk),
    .rst  (rst),
    .evt  (evt),
    .strb (strb)
  );
endmodule

// File: rtl/gic_checker.sv
module gic_checker
  import gic_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [PHASES-1:0] gateUp,
  input logic [PHASES-1:0] gateLo,
  input logic              gateBrk,
  input logic              faultN,
  input evt_t              evt,
  input strb_t             strb
);
  logic [SW-1:0] gateAll;
  assign gateAll = {gateLo, gateUp};

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (gateUp == '0 && gateLo == '0 && !gateBrk && faultN));

  a_r3_no_shoot_through: assert property (@(posedge clk) disable iff (rst)
    (gateUp & gateLo) == '0);

  a_r10_trip_flags_fault: assert property (@(posedge clk) disable iff (rst)
    (strb.scHold != '0) |-> !faultN);

  for (genvar p = 0; p < PHASES; p++) begin : g_ph
    a_r4_overlap_latches: assert property (@(posedge clk) disable iff (rst)
      evt.overlap[p] |=> strb.ilkHold[p]);
    a_r5_lockout_gates_off: assert property (@(posedge clk) disable iff (rst)
      strb.ilkHold[p] |-> (!gateUp[p] && !gateLo[p] && !faultN));
    a_r6_release_on_edge: assert property (@(posedge clk) disable iff (rst)
      $fell(strb.ilkHold[p]) |-> $past(evt.cmdFall[p] || evt.cmdFall[p+PHASES]));
  end

  for (genvar i = 0; i < SW; i++) begin : g_sw
    a_r7_hit_trips: assert property (@(posedge clk) disable iff (rst)
      evt.scHit[i] |=> strb.scHold[i]);
    a_r8_trip_gate_off: assert property (@(posedge clk) disable iff (rst)
      strb.scHold[i] |-> !gateAll[i]);
    a_r8_release_at_pulse: assert property (@(posedge clk) disable iff (rst)
      $fell(strb.scHold[i]) |-> $past(evt.cmdFall[i]));
  end
endmodule

bind gate_interlock_ctrl gic_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .gateUp  (gateUp),
  .gateLo  (gateLo),
  .gateBrk (gateBrk),
  .faultN  (faultN),
  .evt     (evt),
  .strb    (strb)
);

// File: tb/test_gate_interlock_ctrl.sv
`timescale 1ns/1ps
module test_gate_interlock_ctrl;
  import gic_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst = 1'b1;
  logic [PHASES-1:0] cmdUpN = '1;
  logic [PHASES-1:0] cmdLoN = '1;
  logic              brkCmdN = 1'b1;
  logic [SW-1:0]     scSense = '0;
  logic [PHASES-1:0] gateUp, gateLo;
  logic              gateBrk, faultN;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  gate_interlock_ctrl i_gate_interlock_ctrl (
    .clk(clk), .rst(rst), .cmdUpN(cmdUpN), .cmdLoN(cmdLoN), .brkCmdN(brkCmdN),
    .scSense(scSense), .gateUp(gateUp), .gateLo(gateLo), .gateBrk(gateBrk),
    .faultN(faultN)
  );

  // packed view: {faultN, gateBrk, gateLo[2:0], gateUp[2:0]}
  function automatic logic [7:0] obs();
    return {faultN, gateBrk, gateLo, gateUp};
  endfunction

  function automatic logic [7:0] expect_free(logic [2:0] u, logic [2:0] l, logic b);
    logic [2:0] eu, el;
    logic f;
    f = 1'b0;
    for (int p = 0; p < 3; p++) begin
      eu[p] = !u[p] && l[p];
      el[p] = !l[p] && u[p];
      if (!u[p] && !l[p]) f = 1'b1;
    end
    return {!f, !b, el, eu};
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(2);
    check("R1 during reset", obs(), 8'h80);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: outputs quiet after reset with idle commands
    do_reset();
    tick(4);
    check("R1 idle after reset", obs(), 8'h80);

    // R2: exact synchronizer latency
    cmdUpN = 3'b110;
    tick(1);
    check("R2 one edge, still off", obs(), 8'h80);
    tick(1);
    check("R2 two edges, on", obs(), 8'h81);

    // R2 R3 R4 R9 R10: exhaustive command sweep from clean reset
    for (int v = 0; v < 128; v++) begin
      logic [6:0] vv;
      vv = 7'(v);
      cmdUpN  = vv[2:0];
      cmdLoN  = vv[5:3];
      brkCmdN = vv[6];
      do_reset();
      tick(4);
      check("R2/R3/R4/R9/R10 sweep", obs(), expect_free(vv[2:0], vv[5:3], vv[6]));
    end

    // R4 R5 R6: lockout on phase 0, upper restarts first
    cmdUpN = '1; cmdLoN = '1; brkCmdN = 1'b1;
    do_reset();
    tick(2);
    cmdUpN = 3'b110; cmdLoN = 3'b110; tick(4);
    check("R4 overlap phase0", obs(), 8'h00);
    cmdUpN = 3'b100; cmdLoN = 3'b111; tick(4);
    check("R5 lockout held, phase1 free", obs(), 8'h02);
    cmdUpN = 3'b101; tick(4);
    cmdUpN = 3'b100; tick(4);
    check("R6 single restart keeps lock", obs(), 8'h02);
    cmdUpN = 3'b101; tick(4);
    cmdLoN = 3'b110; tick(4);
    check("R6 later edge releases", obs(), 8'h8A);

    // R6: lockout on phase 2, lower restarts first
    cmdUpN = '1; cmdLoN = '1;
    do_reset();
    tick(2);
    cmdUpN = 3'b011; cmdLoN = 3'b011; tick(4);
    check("R4 overlap phase2", obs(), 8'h00);
    cmdUpN = 3'b111; cmdLoN = 3'b111; tick(4);
    check("R5 lock after both released", obs(), 8'h00);
    cmdLoN = 3'b011; tick(4);
    check("R6 lower restart keeps lock", obs(), 8'h00);
    cmdLoN = 3'b111; tick(4);
    cmdUpN = 3'b011; tick(4);
    check("R6 upper later releases", obs(), 8'h84);

    // R7 R8 R10: short-circuit filter and pulse-by-pulse trip
    cmdUpN = '1; cmdLoN = '1;
    do_reset();
    cmdUpN = 3'b101; cmdLoN = 3'b110; tick(4);
    check("R8 baseline", obs(), 8'h8A);
    scSense = 6'b000010; tick(3);
    scSense = '0; tick(6);
    check("R7 short sense ignored", obs(), 8'h8A);
    scSense = 6'b000010; tick(4);
    scSense = '0; tick(6);
    check("R7/R8 trip only upper1", obs(), 8'h08);
    cmdUpN = 3'b111; tick(4);
    check("R8 trip held to next pulse", obs(), 8'h08);
    cmdUpN = 3'b101; tick(4);
    check("R8/R10 next pulse releases", obs(), 8'h8A);
    scSense = 6'b001000; tick(4);
    scSense = '0; tick(6);
    check("R8 trip only lower0", obs(), 8'h02);
    cmdLoN = 3'b111; tick(4);
    cmdLoN = 3'b110; tick(4);
    check("R8/R10 lower released", obs(), 8'h8A);

    // R9: brake ignores overcurrent
    cmdUpN = 3'b110; cmdLoN = 3'b111; brkCmdN = 1'b0;
    do_reset();
    tick(4);
    check("R9 brake on", obs(), 8'hC1);
    scSense = '1; tick(10);
    check("R9 brake immune, bridge tripped", obs(), 8'h40);
    scSense = '0; brkCmdN = 1'b1; tick(4);
    check("R9 brake off follows command", obs(), 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule